// File: doc/BRIEF.md
# Multi-Source Counter Array Timebase

This block is a shared 16-bit up-counting timebase with three capture/compare channels. The counter advances on a count-enable pulse taken from one of six sources. Three of them come from the system clock: the clock itself, the clock divided by 12 and the clock divided by 4. One is an overflow pulse from another timer. The last two are asynchronous: an external clock pin, and an external oscillator divided by 8. Both are brought into the system clock domain, and the counter steps once for each rising edge that is detected.

Each channel has a mode and a 16-bit value register. In capture mode, a rising edge on the channel's input stores the counter into the value register. In compare mode, the channel raises its flag when the counter steps onto the value. Toggle mode does the same and also inverts the channel's match output. A run bit gates counting. Software can load the counter only while it is stopped. Overflow and channel flags are sticky and are cleared by writing ones to them.

All registers are reached through a write port and a combinational read port, each with an address.

Top module: `cnt_array_timebase`

## Requirements
- R1: After reset the counter, the overflow flag, all channel flags, all match outputs and the control register (address 0) read zero.
- R2: Source code 0 steps the counter once per 12 system clocks of running, and code 1 once per 4. The prescaler restarts from zero when run is set, so N running clocks give floor(N/12) or floor(N/4) steps.
- R3: Source code 4 steps the counter on every running clock. Code 2 steps it once for each one-cycle pulse on the timer-overflow input.
- R4: Source code 3 steps the counter once per rising edge of the external clock pin. Code 5 steps it once per 8 external oscillator cycles. Both pass through a two-stage synchronizer.
- R5: Source codes 6 and 7 freeze the counter even while run is set.
- R6: Control register (address 0) holds run in bit 0 and the source code in bits 3:1. The counter (address 2) holds its value whenever run is clear, accepts a write only while run is clear, and ignores a write while run is set.
- R7: A step from 0xFFFF to 0x0000 sets the overflow flag (flag register address 1, bit 0, also on `ovf_irq`). The flag stays set until a write to address 1 with bit 0 set.
- R8: Channel k has its mode at address 3+2k (bits 1:0: 0 off, 1 capture, 2 compare, 3 toggle) and its value at address 4+2k. In capture mode, a rising edge on `cap_in[k]` stores the counter value at the second clock after the edge is sampled and sets flag bit k+1. With the mode off, the edge changes neither the value nor the flag.
- R9: In compare mode, a counter step onto the channel value sets flag bit k+1 and leaves `match_out[k]` unchanged. Loading the counter with that value does not set the flag.
- R10: In toggle mode, every such step also inverts `match_out[k]`. The output changes in no other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xosc_clk | input | 1 | External oscillator clock |
| t0_ovf | input | 1 | One-cycle overflow pulse from another timer |
| eci_in | input | 1 | External count clock pin, asynchronous |
| cap_in | input | 3 | Capture inputs, one per channel, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| count | output | 16 | Current counter value |
| match_out | output | 3 | Toggle-mode outputs, one per channel |
| ovf_irq | output | 1 | Sticky overflow flag |
| ch_irq | output | 3 | Sticky channel flags |

## Verification
The assertions check the following on every cycle:
- the counter stays still while stopped or on an unused source code;
- a running counter only ever moves by exactly one;
- a wrap always leaves the overflow flag set, and the flag survives until a clear is written;
- a match output never changes without its channel flag set.

Only the bench's scenarios can show the rates, because they depend on counting over many cycles. This covers the exact rates of the divided sources, the pulse and edge counts of the asynchronous sources, the exact captured value after synchronizer latency, and that a counter write is ignored while running.

// File: rtl/cat_pkg.sv
package cat_pkg;
   localparam logic [2:0] SRC_DIV_SLOW = 3'd0;
   localparam logic [2:0] SRC_DIV_FAST = 3'd1;
   localparam logic [2:0] SRC_T0       = 3'd2;
   localparam logic [2:0] SRC_PIN      = 3'd3;
   localparam logic [2:0] SRC_SYS      = 3'd4;
   localparam logic [2:0] SRC_XOSC     = 3'd5;

   localparam logic [1:0] MODE_OFF  = 2'd0;
   localparam logic [1:0] MODE_CAPT = 2'd1;
   localparam logic [1:0] MODE_CMP  = 2'd2;
   localparam logic [1:0] MODE_TOG  = 2'd3;

   localparam int REG_CTRL    = 0;
   localparam int REG_FLAGS   = 1;
   localparam int REG_COUNT   = 2;
   localparam int REG_CH_BASE = 3;

   function automatic int ch_mode_addr(input int k);
      return REG_CH_BASE + 2 * k;
   endfunction

   function automatic int ch_val_addr(input int k);
      return REG_CH_BASE + 2 * k + 1;
   endfunction
endpackage

// File: rtl/cat_sync_edge.sv
module cat_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cat_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         prev_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], d};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cat_src_sel.sv
module cat_src_sel #(
   parameter int DIV_SLOW    = 12,
   parameter int DIV_FAST    = 4,
   parameter int XOSC_DIV    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       xosc_clk,
   input  logic       run,
   input  logic [2:0] src,
   input  logic       t0_ovf,
   input  logic       eci_in,
   output logic       tick
);
   import cat_pkg::*;

   localparam int N_PRE = 2;
   localparam int HALF  = XOSC_DIV / 2;
   localparam int XW    = $clog2(HALF);

   if (DIV_SLOW < 2 || DIV_FAST < 2) begin : g_bad_div
      $error("cat_src_sel: prescale ratios must be at least 2");
   end
   if (XOSC_DIV < 4 || (XOSC_DIV % 2) != 0) begin : g_bad_xdiv
      $error("cat_src_sel: XOSC_DIV must be even and at least 4");
   end

   logic [N_PRE-1:0] pre_tick;

   for (genvar g = 0; g < N_PRE; g++) begin : g_pre
      localparam int D = (g == 0) ? DIV_SLOW : DIV_FAST;
      localparam int W = $clog2(D);
      logic [W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            pre_q <= '0;
         else if (!run || pre_q == W'(D - 1))   pre_q <= '0;
         else                                   pre_q <= pre_q + 1'b1;
      end
      assign pre_tick[g] = run && (pre_q == W'(D - 1));
   end

   logic [XW-1:0] xc_q;
   logic          xdiv_q;

   always_ff @(posedge xosc_clk or negedge rst_n) begin
      if (!rst_n) begin
         xc_q   <= '0;
         xdiv_q <= 1'b0;
      end else if (xc_q == XW'(HALF - 1)) begin
         xc_q   <= '0;
         xdiv_q <= ~xdiv_q;
      end else begin
         xc_q   <= xc_q + 1'b1;
      end
   end

   logic xosc_rise, pin_rise;

   cat_sync_edge #(.STAGES(SYNC_STAGES)) u_xosc_sync (
      .clk(clk), .rst_n(rst_n), .d(xdiv_q), .rise(xosc_rise)
   );

   cat_sync_edge #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(eci_in), .rise(pin_rise)
   );

   always_comb begin
      case (src)
         SRC_DIV_SLOW: tick = pre_tick[0];
         SRC_DIV_FAST: tick = pre_tick[1];
         SRC_T0:       tick = t0_ovf;
         SRC_PIN:      tick = pin_rise;
         SRC_SYS:      tick = 1'b1;
         SRC_XOSC:     tick = xosc_rise;
         default:      tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/cat_channel.sv
module cat_channel #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             cap_in,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] count_next,
   input  logic             adv,
   input  logic             val_wr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] val,
   output logic             flag,
   output logic             tog
);
   import cat_pkg::*;

   logic cap_rise, capture, hit;

   cat_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
      .clk(clk), .rst_n(rst_n), .d(cap_in), .rise(cap_rise)
   );

   assign capture = (mode == MODE_CAPT) && cap_rise;
   assign hit     = ((mode == MODE_CMP) || (mode == MODE_TOG)) && adv
                    && (count_next == val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val  <= '0;
         flag <= 1'b0;
         tog  <= 1'b0;
      end else begin
         if (capture)     val <= count;
         else if (val_wr) val <= wr_data;

         if (capture || hit) flag <= 1'b1;
         else if (flag_clr)  flag <= 1'b0;

         if (hit && mode == MODE_TOG) tog <= ~tog;
      end
   end
endmodule

// File: rtl/cnt_array_timebase.sv
module cnt_array_timebase #(
   parameter int CNT_W       = 16,
   parameter int N_CH        = 3,
   parameter int ADDR_W      = 4,
   parameter int DIV_SLOW    = 12,
   parameter int DIV_FAST    = 4,
   parameter int XOSC_DIV    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xosc_clk,
   input  logic              t0_ovf,
   input  logic              eci_in,
   input  logic [N_CH-1:0]   cap_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic [CNT_W-1:0]  count,
   output logic [N_CH-1:0]   match_out,
   output logic              ovf_irq,
   output logic [N_CH-1:0]   ch_irq
);
   import cat_pkg::*;

   localparam int N_REGS = REG_CH_BASE + 2 * N_CH;

   if (N_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("cnt_array_timebase: ADDR_W too small for the channel count");
   end
   if (CNT_W < 4 || CNT_W < N_CH + 1) begin : g_bad_width
      $error("cnt_array_timebase: CNT_W too small for control or flag fields");
   end

   logic                        run_q;
   logic [2:0]                  src_q;
   logic [CNT_W-1:0]            cnt_q, cnt_next;
   logic                        ovf_q;
   logic [N_CH-1:0][1:0]        mode_q;
   logic [N_CH-1:0][CNT_W-1:0]  ch_val;
   logic                        tick, adv;
   logic                        ctrl_wr, cnt_wr, flags_wr, ovf_clr;

   assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
   assign cnt_wr   = wr_en && (wr_addr == ADDR_W'(REG_COUNT));
   assign flags_wr = wr_en && (wr_addr == ADDR_W'(REG_FLAGS));
   assign ovf_clr  = flags_wr && wr_data[0];

   cat_src_sel #(
      .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
      .XOSC_DIV(XOSC_DIV), .SYNC_STAGES(SYNC_STAGES)
   ) u_src (
      .clk(clk), .rst_n(rst_n), .xosc_clk(xosc_clk), .run(run_q),
      .src(src_q), .t0_ovf(t0_ovf), .eci_in(eci_in), .tick(tick)
   );

   assign adv      = run_q && tick;
   assign cnt_next = cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         src_q  <= '0;
         cnt_q  <= '0;
         ovf_q  <= 1'b0;
         mode_q <= '0;
      end else begin
         if (ctrl_wr) begin
            run_q <= wr_data[0];
            src_q <= wr_data[3:1];
         end

         if (adv)                  cnt_q <= cnt_next;
         else if (cnt_wr && !run_q) cnt_q <= wr_data;

         if (adv && cnt_q == '1) ovf_q <= 1'b1;
         else if (ovf_clr)       ovf_q <= 1'b0;

         for (int k = 0; k < N_CH; k++) begin
            if (wr_en && wr_addr == ADDR_W'(ch_mode_addr(k)))
               mode_q[k] <= wr_data[1:0];
         end
      end
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      logic val_wr, flag_clr;
      assign val_wr   = wr_en && (wr_addr == ADDR_W'(ch_val_addr(g)));
      assign flag_clr = flags_wr && wr_data[g+1];

      cat_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .clk(clk), .rst_n(rst_n), .mode(mode_q[g]), .cap_in(cap_in[g]),
         .count(cnt_q), .count_next(cnt_next), .adv(adv),
         .val_wr(val_wr), .wr_data(wr_data), .flag_clr(flag_clr),
         .val(ch_val[g]), .flag(ch_irq[g]), .tog(match_out[g])
      );
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_CTRL))  rd_data = CNT_W'({src_q, run_q});
      if (rd_addr == ADDR_W'(REG_FLAGS)) rd_data = CNT_W'({ch_irq, ovf_q});
      if (rd_addr == ADDR_W'(REG_COUNT)) rd_data = cnt_q;
      for (int k = 0; k < N_CH; k++) begin
         if (rd_addr == ADDR_W'(ch_mode_addr(k))) rd_data = CNT_W'(mode_q[k]);
         if (rd_addr == ADDR_W'(ch_val_addr(k)))  rd_data = ch_val[k];
      end
   end

   assign count   = cnt_q;
   assign ovf_irq = ovf_q;
endmodule

// File: rtl/cat_checker.sv
module cat_checker #(
   parameter int CNT_W = 16,
   parameter int N_CH  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic [2:0]       src,
   input logic             cnt_wr,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] count,
   input logic             ovf,
   input logic [N_CH-1:0]  ch_irq,
   input logic [N_CH-1:0]  match_out
);
   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(count)); // R6

   AST_UNUSED_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (src >= 3'd6 && !cnt_wr) |=> $stable(count)); // R5

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$stable(count)) |-> (count == CNT_W'($past(count) + 1'b1))); // R3

   AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && $past(count) == '1 && count == '0) |-> ovf); // R7

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ovf) && !$past(ovf_clr)) |-> ovf); // R7

   AST_TOGGLE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (match_out != $past(match_out)) |-> (((match_out ^ $past(match_out)) & ~ch_irq) == '0)); // R10
endmodule

bind cnt_array_timebase cat_checker #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q), .src(src_q), .cnt_wr(cnt_wr),
   .ovf_clr(ovf_clr), .count(count), .ovf(ovf_irq), .ch_irq(ch_irq),
   .match_out(match_out)
);

// File: tb/cnt_array_timebase_tb_top.sv
module cnt_array_timebase_tb_top;
   localparam int CW = 16;
   localparam int NC = 3;
   localparam int AW = 4;

   logic          clk = 1'b0, xosc_clk = 1'b0, rst_n = 1'b0;
   logic          t0_ovf = 1'b0, eci_in = 1'b0;
   logic [NC-1:0] cap_in = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [CW-1:0] rd_data, count;
   logic [NC-1:0] match_out, ch_irq;
   logic          ovf_irq;

   int n_run = 0, n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;
   always #13 xosc_clk = ~xosc_clk;

   cnt_array_timebase dut_i (
      .clk(clk), .rst_n(rst_n), .xosc_clk(xosc_clk), .t0_ovf(t0_ovf),
      .eci_in(eci_in), .cap_in(cap_in), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .count(count),
      .match_out(match_out), .ovf_irq(ovf_irq), .ch_irq(ch_irq)
   );

   function automatic int exp_steps(input int edges, input int div);
      return edges / div;
   endfunction

   function automatic int ctrl_word(input int src, input int run);
      return (src << 1) | run;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      n_run++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      rd_addr = AW'(a);
      #1 d = int'(rd_data);
   endtask

   // Loads start, runs source src for K+1 counted edges, stops, reads back.
   task automatic run_for(input int src, input int start, input int k, output int v);
      wr(2, start);
      wr(0, ctrl_word(src, 1));
      repeat (k) @(posedge clk);
      wr(0, ctrl_word(src, 0));
      rd(2, v);
   endtask

   initial begin
      int v, k, n, st, v0;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 count", int'(count), 0);
      chk("R1 ovf", int'(ovf_irq), 0);
      chk("R1 ch flags", int'(ch_irq), 0);
      chk("R1 match", int'(match_out), 0);
      rd(0, v); chk("R1 ctrl", v, 0);

      // R2 prescaled sources, R3 system clock
      for (int i = 0; i < 3; i++) begin
         k = $urandom_range(30, 150);
         run_for(0, 0, k, v); chk("R2 div12", v, exp_steps(k + 1, 12));
         k = $urandom_range(10, 80);
         run_for(1, 0, k, v); chk("R2 div4", v, exp_steps(k + 1, 4));
         k = $urandom_range(5, 60); st = $urandom_range(0, 1000);
         run_for(4, st, k, v); chk("R3 sysclk", v, st + k + 1);
      end

      // R3 timer overflow pulses
      wr(2, 0);
      wr(0, ctrl_word(2, 1));
      n = $urandom_range(3, 10);
      for (int j = 0; j < n; j++) begin
         repeat ($urandom_range(1, 5)) @(negedge clk);
         t0_ovf = 1'b1;
         @(negedge clk) t0_ovf = 1'b0;
      end
      repeat (2) @(posedge clk);
      wr(0, ctrl_word(2, 0));
      rd(2, v); chk("R3 t0 pulses", v, n);

      // R4 external pin edges
      wr(2, 0);
      wr(0, ctrl_word(3, 1));
      n = $urandom_range(3, 8);
      repeat (4) @(negedge clk);
      for (int j = 0; j < n; j++) begin
         eci_in = 1'b1;
         repeat (4) @(negedge clk);
         eci_in = 1'b0;
         repeat (4) @(negedge clk);
      end
      repeat (6) @(posedge clk);
      wr(0, ctrl_word(3, 0));
      rd(2, v); chk("R4 pin edges", v, n);

      // R4 external oscillator / 8 (208 ns period against 10 ns clock)
      k = 400;
      run_for(5, 0, k, v);
      chk_rng("R4 xosc div8", v, ((k + 1) * 10) / 208 - 1, ((k + 1) * 10) / 208 + 2);

      // R5 unused codes freeze the counter
      run_for(6, 16'h55, 50, v); chk("R5 code6", v, 16'h55);
      run_for(7, 16'h66, 50, v); chk("R5 code7", v, 16'h66);

      // R6 counter write ignored while running, taken while stopped
      wr(2, 0);
      wr(0, ctrl_word(4, 1));
      k = $urandom_range(5, 20);
      repeat (k) @(posedge clk);
      wr(2, 16'h1234);
      repeat (7) @(posedge clk);
      wr(0, ctrl_word(4, 0));
      rd(2, v); chk("R6 write while running ignored", v, k + 7 + 2);
      wr(2, 16'hBEEF);
      repeat (20) @(posedge clk);
      rd(2, v); chk("R6 stopped load and hold", v, 16'hBEEF);
      rd(0, v); chk("R6 ctrl readback", v, ctrl_word(4, 0));

      // R7 overflow
      run_for(4, 16'hFFFD, 4, v);
      chk("R7 wrapped value", v, 2);
      chk("R7 ovf port", int'(ovf_irq), 1);
      rd(1, v); chk("R7 ovf bit", v & 1, 1);
      wr(1, 0);
      rd(1, v); chk("R7 ovf sticky", v & 1, 1);
      wr(1, 1);
      chk("R7 ovf cleared", int'(ovf_irq), 0);

      // R8 capture on channel 2
      wr(7, 1);
      for (int i = 0; i < 3; i++) begin
         k = $urandom_range(5, 40);
         wr(1, 8);
         wr(2, 0);
         wr(0, ctrl_word(4, 1));
         repeat (k) @(posedge clk);
         @(negedge clk) cap_in[2] = 1'b1;
         repeat (6) @(posedge clk);
         @(negedge clk) cap_in[2] = 1'b0;
         wr(0, ctrl_word(4, 0));
         rd(8, v); chk("R8 captured value", v, k + 2);
         chk("R8 capture flag", int'(ch_irq[2]), 1);
      end
      wr(7, 0);
      wr(1, 8);
      rd(8, v0);
      wr(0, ctrl_word(4, 1));
      repeat (4) @(negedge clk);
      cap_in[2] = 1'b1;
      repeat (6) @(negedge clk);
      cap_in[2] = 1'b0;
      wr(0, ctrl_word(4, 0));
      rd(8, v); chk("R8 mode off keeps value", v, v0);
      chk("R8 mode off keeps flag", int'(ch_irq[2]), 0);

      // R9 compare on channel 0
      wr(3, 2);
      k = $urandom_range(20, 60);
      wr(4, k);
      wr(1, 2);
      run_for(4, 0, k - 4, v);
      chk("R9 no flag before match", int'(ch_irq[0]), 0);
      wr(2, k);
      chk("R9 load is not a match", int'(ch_irq[0]), 0);
      run_for(4, 0, k + 3, v);
      chk("R9 flag on match", int'(ch_irq[0]), 1);
      chk("R9 output unchanged", int'(match_out[0]), 0);

      // R10 toggle on channel 1
      wr(5, 3);
      k = $urandom_range(20, 60);
      wr(6, k);
      wr(1, 4);
      run_for(4, 0, k - 5, v);
      chk("R10 no toggle before match", int'(match_out[1]), 0);
      run_for(4, 0, k + 2, v);
      chk("R10 first toggle", int'(match_out[1]), 1);
      chk("R10 flag", int'(ch_irq[1]), 1);
      wr(1, 4);
      run_for(4, 0, k + 2, v);
      chk("R10 second toggle", int'(match_out[1]), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      finished = 1'b1;
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule